// File: doc/BRIEF.md
# Burst column address sequencer

This block produces the column address for each data beat of a read or write burst in a double-data-rate memory controller. A single start strobe loads a starting column, a length code and an order type. From the next cycle, one address appears per clock with a valid flag. A last flag marks the final beat.

The burst stays inside an aligned block whose size equals the burst length: 2, 4 or 8 columns. The low offset bits step through that block in one of two orders. Sequential order counts upward from the starting offset and wraps at the block edge. Interleaved order XORs the starting offset with the beat index. Column bits above the block never change during a burst.

A start strobe that arrives while a burst is running is ignored, with two exceptions: it is taken in the cycle that shows the last beat, and it is taken whenever the abort input is high. Taking a start on the last beat allows back-to-back bursts with no gap. The abort input can end a burst early, or replace it with a new one at once.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, and until the first start is taken, valid_o and last_o are low.
- R2: When start_i is high at a clock edge while idle, the next cycle shows valid_o high with col_o equal to col_i as sampled at that edge.
- R3: len_i selects the beat count: code 0 gives 2 beats, code 1 gives 4, and codes 2 and 3 both give 8. Beats appear on consecutive cycles. last_o is high on the final beat only.
- R4: With type_i = 0 (sequential), the low log2(L) bits on beat i equal (start offset + i) mod L, where L is the burst length.
- R5: With type_i = 1 (interleaved), the low log2(L) bits on beat i equal the start offset XOR i.
- R6: The col_o bits above the low log2(L) bits equal those of the starting column on every beat.
- R7: A start_i during a burst, on any beat except the last, has no effect on the burst and is not remembered. A start_i on the last beat begins a new burst in the following cycle, with no gap.
- R8: abort_i high on an active beat with start_i low makes valid_o low in the next cycle. abort_i together with start_i begins the new burst in the next cycle.
- R9: After the last beat, if no start is taken, valid_o is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a burst |
| col_i | input | COL_W | Starting column address |
| len_i | input | 2 | Length code: 0=2, 1=4, 2 or 3=8 |
| type_i | input | 1 | Order type: 0 sequential, 1 interleaved |
| abort_i | input | 1 | Ends the current burst; with start_i, restarts it |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat |

## Verification
A wrong beat counter shows up directly in col_o, because every beat carries its own expected offset. It also shows in last_o: a burst that comes out too short or too long moves the last flag, and the bench sees the mismatch on the first bad beat.

A fault in the captured length or base affects the very first beat, or the beat where the block should wrap. A fault in start filtering changes the address on the beat that follows the stray strobe. The bench compares every beat of every burst against a model of the wrap and XOR rules.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned OFF_W = 3;

  typedef enum logic [1:0] {
    LEN_2  = 2'd0,
    LEN_4  = 2'd1,
    LEN_8  = 2'd2,
    LEN_8B = 2'd3
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
(
  input  logic [1:0]       len_i,
  output logic [OFF_W-1:0] mask_o
);
  always_comb begin
    unique case (len_code_e'(len_i))
      LEN_2:   mask_o = 3'b001;
      LEN_4:   mask_o = 3'b011;
      default: mask_o = 3'b111;
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_col_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             abort_i,
  input  logic [OFF_W-1:0] beat_max_i,
  output logic [OFF_W-1:0] beat_o,
  output logic             busy_o,
  output logic             last_o
);
  logic [OFF_W-1:0] beat_q;
  logic             busy_q;

  assign last_o = busy_q && (beat_q == beat_max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      beat_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (abort_i || last_o) begin
        busy_q <= 1'b0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign beat_o = beat_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [OFF_W-1:0] mask_i,
  input  logic [OFF_W-1:0] beat_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  localparam int unsigned HI_W = COL_W - OFF_W;

  logic [OFF_W-1:0] start_off;
  logic [OFF_W-1:0] step_off;

  assign start_off = base_i[OFF_W-1:0];
  // sequential adds, interleaved xors; the mask keeps the result inside the block
  assign step_off  = ilv_i ? (start_off ^ beat_i) : (start_off + beat_i);

  assign col_o = {base_i[COL_W-1:OFF_W],
                  (start_off & ~mask_i) | (step_off & mask_i)};

  if (HI_W < 1) begin : g_bad_width
    initial $error("COL_W must exceed OFF_W");
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       len_i,
  input  logic             type_i,
  input  logic             abort_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] base_q;
  logic [OFF_W-1:0] mask_q, mask_d, beat;
  order_e           ord_q;
  logic             busy, last, accept;

  burst_len_decode u_len (
    .len_i  (len_i),
    .mask_o (mask_d)
  );

  // new start only when idle, on the final beat, or under abort
  assign accept = start_i && (!busy || last || abort_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      ord_q  <= ORD_SEQ;
    end else if (accept) begin
      base_q <= col_i;
      mask_q <= mask_d;
      ord_q  <= order_e'(type_i);
    end
  end

  burst_beat_ctr u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .abort_i    (abort_i),
    .beat_max_i (mask_q),
    .beat_o     (beat),
    .busy_o     (busy),
    .last_o     (last)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .mask_i (mask_q),
    .beat_i (beat),
    .ilv_i  (ord_q == ORD_ILV),
    .col_o  (col_o)
  );

  assign valid_o = busy;
  assign last_o  = last;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             abort_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  // R3
  last_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  // R2
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && start_i) |=> valid_o);

  // R7
  burst_continues_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !abort_i) |=> valid_o);

  // R6
  high_bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !abort_i) |=> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]));

  // R8
  abort_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && abort_i && !start_i) |=> !valid_o);

  // R9
  end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .abort_i (abort_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .last_o  (last_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int unsigned COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [1:0]       len_i = '0;
  logic             type_i = 1'b0;
  logic             abort_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .col_i   (col_i),
    .len_i   (len_i),
    .type_i  (type_i),
    .abort_i (abort_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o)
  );

  function automatic int blen(input logic [1:0] l);
    return (l == 2'd0) ? 2 : (l == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] c,
      input logic [1:0] l, input logic t, input int i);
    int m   = blen(l) - 1;
    int off = c & m;
    int nw  = t ? (off ^ i) : ((off + i) & m);
    return COL_W'((c & ~m) | (nw & m));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // call at a negedge; leaves start asserted over the next posedge
  task automatic drive_start(input logic [COL_W-1:0] c, input logic [1:0] l, input logic t);
    start_i = 1'b1; col_i = c; len_i = l; type_i = t;
  endtask

  // at negedge showing beat i: check valid, address, last
  task automatic chk_beat(input string req, input logic [COL_W-1:0] c,
      input logic [1:0] l, input logic t, input int i);
    chk({req, " valid"}, valid_o, 1'b1);
    chk({req, " col"}, col_o, exp_col(c, l, t, i));
    chk({req, " last"}, last_o, (i == blen(l) - 1));
  endtask

  task automatic run_burst(input string req, input logic [COL_W-1:0] c,
      input logic [1:0] l, input logic t);
    drive_start(c, l, t);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < blen(l); i++) begin
      chk_beat(req, c, l, t, i);
      @(negedge clk);
    end
    chk("R9 idle after last", valid_o, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed));
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", valid_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", valid_o, 1'b0);
    chk("R1 last after reset", last_o, 1'b0);

    // directed: document-style orders
    run_burst("R4 seq L8 start5", 10'h125, 2'd2, 1'b0);
    run_burst("R5 ilv L8 start1", 10'h0b1, 2'd2, 1'b1);
    run_burst("R5 ilv L8 start6", 10'h3fe, 2'd2, 1'b1);
    run_burst("R4 seq L4 start3", 10'h2a7, 2'd1, 1'b0);
    run_burst("R5 ilv L4 start3", 10'h2a7, 2'd1, 1'b1);
    run_burst("R3 L2 start1", 10'h155, 2'd0, 1'b0);
    run_burst("R3 code3 as 8", 10'h00b, 2'd3, 1'b0);
    run_burst("R6 high bits L2", 10'h3ff, 2'd0, 1'b1);

    // R7: stray start mid-burst is ignored
    drive_start(10'h013, 2'd2, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk_beat("R7 ignore", 10'h013, 2'd2, 1'b0, i);
      if (i == 2) begin
        start_i = 1'b1; col_i = 10'h2c0; len_i = 2'd0; type_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    chk("R7 stray not remembered", valid_o, 1'b0);

    // R7: back-to-back via start on last beat
    drive_start(10'h0f2, 2'd1, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk_beat("R7 chain a", 10'h0f2, 2'd1, 1'b1, i);
      if (i == 3) drive_start(10'h31d, 2'd2, 1'b0);
      @(negedge clk);
    end
    start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk_beat("R7 chain b", 10'h31d, 2'd2, 1'b0, i);
      @(negedge clk);
    end
    chk("R9 after chain", valid_o, 1'b0);

    // R8: abort alone
    drive_start(10'h044, 2'd2, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
    chk_beat("R8 pre-abort", 10'h044, 2'd2, 1'b1, 0);
    @(negedge clk);
    chk_beat("R8 pre-abort", 10'h044, 2'd2, 1'b1, 1);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk("R8 abort ends", valid_o, 1'b0);
    chk("R8 abort last", last_o, 1'b0);

    // R8: abort with start restarts
    drive_start(10'h1e6, 2'd2, 1'b0);
    @(negedge clk);
    start_i = 1'b0;
    chk_beat("R8 first", 10'h1e6, 2'd2, 1'b0, 0);
    abort_i = 1'b1;
    drive_start(10'h209, 2'd1, 1'b1);
    @(negedge clk);
    abort_i = 1'b0; start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk_beat("R8 restart", 10'h209, 2'd1, 1'b1, i);
      @(negedge clk);
    end
    chk("R9 after restart", valid_o, 1'b0);

    // random bursts, R4 R5 R6 R3 coverage
    for (int n = 0; n < 60; n++) begin
      logic [COL_W-1:0] c = COL_W'($urandom);
      logic [1:0]       l = 2'($urandom);
      logic             t = 1'($urandom);
      run_burst(t ? "R5 rand" : "R4 rand", c, l, t);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule